// File: doc/BRIEF.md
# Transmit Completion Auto-Release Controller

This block decides what happens each time the transmitter of a packet-buffer Ethernet MAC finishes a packet. For every completion it receives a packet number and two flags, success and fatal error. It then chooses whether to return that packet's buffer pages to the memory allocator, whether to record the packet number in a small completion FIFO that the CPU reads, and which interrupt status bit to set.

There are two modes. In manual mode every completed packet number is queued for the CPU and nothing is freed automatically. In auto-release mode a successful packet is freed silently and never reaches the FIFO, so the CPU only hears about a sequence when it ends or when it breaks. A fatal error stops the transmitter, raises the transmit interrupt and holds the failing packet number with its pages intact. The CPU restarts the sequence by enabling the transmitter again, and the block then hands the held packet number back to the transmitter.

Top module: `tx_autorel_ctrl`

## Requirements
- R1: After reset the transmitter enable and the auto-release mode are off, the FIFO is empty and not full, the overflow flag, both interrupt bits and the failed-packet flag are clear, and neither the release pulse nor the restart pulse is active.
- R2: In auto-release mode, a completion with success high and fatal low produces a one-cycle `rel_valid` pulse carrying that packet number in the cycle after the event, and writes nothing to the completion FIFO.
- R3: In manual mode (auto-release off), every accepted completion writes its packet number into the completion FIFO, whatever its flags, and `rel_valid` stays low. The FIFO returns entries in arrival order.
- R4: A completion with fatal high is treated as fatal whatever its success flag. It sets `irq_tx`, clears `txena`, latches the packet number into `fail_pkt` with `fail_valid` high, and produces no release. In auto-release mode it is not written to the FIFO; in manual mode it is.
- R5: While `txena` is low, completion events are ignored: no release, no FIFO write, no interrupt change.
- R6: An accepted completion with `done_last` high and fatal low sets `irq_txempty`, in either mode.
- R7: In manual mode every accepted completion sets `irq_tx`. In auto-release mode only fatal completions set it.
- R8: In auto-release mode, a completion with success low and fatal low is written to the FIFO, is not released, and sets no interrupt.
- R9: The FIFO holds `CF_DEPTH` (default 8) entries and shows empty and full flags. A write while full is dropped, even if a read happens in the same cycle, and sets the sticky `cf_ovf` bit. A read while empty has no effect.
- R10: A `cpu_txena_set` pulse sets `txena`. If `fail_valid` is high, it also gives a one-cycle `restart_valid` pulse carrying `fail_pkt` and clears `fail_valid`. A fatal event in the same cycle takes priority in clearing `txena`.
- R11: `irq_clr` bit 0 clears `irq_tx`, bit 1 clears `irq_txempty` and bit 2 clears `cf_ovf`. All three bits stay set until cleared, and a new set event in the same cycle as a clear leaves the bit set.
- R12: A `cfg_wr` pulse loads `cfg_auto` into the mode bit. An event in the same cycle is handled with the mode that was in force before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load the mode bit |
| cfg_auto | input | 1 | Mode value: 1 selects auto-release |
| cpu_txena_set | input | 1 | CPU pulse that enables the transmitter |
| irq_clr | input | 3 | Write-one-clear: bit0 irq_tx, bit1 irq_txempty, bit2 cf_ovf |
| done_valid | input | 1 | Completion event strobe |
| done_pkt | input | PKT_W | Packet number of the completed packet |
| done_ok | input | 1 | Packet was sent successfully |
| done_fatal | input | 1 | Packet hit a fatal error |
| done_last | input | 1 | Packet was the last one in the queued sequence |
| cf_rd | input | 1 | Pop the completion FIFO head |
| auto_rel | output | 1 | Current mode bit |
| txena | output | 1 | Transmitter enable |
| rel_valid | output | 1 | Page-release request strobe |
| rel_pkt | output | PKT_W | Packet number to release |
| cf_dout | output | PKT_W | Completion FIFO head |
| cf_empty | output | 1 | FIFO empty |
| cf_full | output | 1 | FIFO full |
| cf_ovf | output | 1 | Sticky FIFO overflow |
| irq_tx | output | 1 | Transmit interrupt status |
| irq_txempty | output | 1 | Sequence-complete interrupt status |
| fail_valid | output | 1 | A failed packet is being held |
| fail_pkt | output | PKT_W | Held failed packet number |
| restart_valid | output | 1 | Resume strobe to the transmitter |
| restart_pkt | output | PKT_W | Packet number to resume from |

## Verification
The directed phase runs separate streams. A stream of successes in manual mode must show up in the FIFO in arrival order. The same stream in auto mode must turn into release pulses and leave the FIFO untouched. A mix of non-fatal failures separates the FIFO-but-no-release path from both of those. A fatal packet in the middle of a sequence, with events still arriving while stopped, shows that the sequence freezes and that the CPU restart hands back the held number. Writing more than eight entries, and making clears and sets collide, exercises the sticky overflow and the priority of set over clear. A random phase then mixes every input, including mode writes in the same cycle as events. A behavioural model is compared against the block on every clock.

// File: rtl/tx_autorel_ctrl.sv
module tx_autorel_ctrl #(
  parameter int PKT_W    = 6,
  parameter int CF_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_auto,
  input  logic             cpu_txena_set,
  input  logic [2:0]       irq_clr,
  input  logic             done_valid,
  input  logic [PKT_W-1:0] done_pkt,
  input  logic             done_ok,
  input  logic             done_fatal,
  input  logic             done_last,
  input  logic             cf_rd,
  output logic             auto_rel,
  output logic             txena,
  output logic             rel_valid,
  output logic [PKT_W-1:0] rel_pkt,
  output logic [PKT_W-1:0] cf_dout,
  output logic             cf_empty,
  output logic             cf_full,
  output logic             cf_ovf,
  output logic             irq_tx,
  output logic             irq_txempty,
  output logic             fail_valid,
  output logic [PKT_W-1:0] fail_pkt,
  output logic             restart_valid,
  output logic [PKT_W-1:0] restart_pkt
);

  localparam int AW    = (CF_DEPTH > 1) ? $clog2(CF_DEPTH) : 1;
  localparam int CW    = $clog2(CF_DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(CF_DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(CF_DEPTH);

  logic [PKT_W-1:0] mem [CF_DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;

  wire take    = done_valid & txena;
  wire fatal   = take & done_fatal;
  wire good    = take & done_ok & ~done_fatal;
  wire do_rel  = good & auto_rel;
  wire do_wr   = take & (~auto_rel | (~done_ok & ~done_fatal));
  wire wr_ok   = do_wr & ~cf_full;
  wire rd_ok   = cf_rd & ~cf_empty;
  wire set_itx = fatal | (take & ~auto_rel);
  wire set_iem = take & done_last & ~done_fatal;
  wire restart = cpu_txena_set & fail_valid;

  assign cf_empty = (cnt == '0);
  assign cf_full  = (cnt == FULL);
  assign cf_dout  = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_rel <= 1'b0;
      txena    <= 1'b0;
    end else begin
      if (cfg_wr) auto_rel <= cfg_auto;
      if (fatal) txena <= 1'b0;
      else if (cpu_txena_set) txena <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_valid     <= 1'b0;
      rel_pkt       <= '0;
      restart_valid <= 1'b0;
      restart_pkt   <= '0;
    end else begin
      rel_valid     <= do_rel;
      restart_valid <= restart;
      if (do_rel) rel_pkt <= done_pkt;
      if (restart) restart_pkt <= fail_pkt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_valid <= 1'b0;
      fail_pkt   <= '0;
    end else if (fatal) begin
      fail_valid <= 1'b1;
      fail_pkt   <= done_pkt;
    end else if (restart) begin
      fail_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_tx      <= 1'b0;
      irq_txempty <= 1'b0;
      cf_ovf      <= 1'b0;
    end else begin
      irq_tx      <= set_itx | (irq_tx & ~irq_clr[0]);
      irq_txempty <= set_iem | (irq_txempty & ~irq_clr[1]);
      cf_ovf      <= (do_wr & cf_full) | (cf_ovf & ~irq_clr[2]);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= done_pkt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (rd_ok) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  assert_fatal_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && txena && done_fatal) |=> (!txena && irq_tx && fail_valid && !rel_valid));

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !txena && !cfg_wr) |=> !rel_valid);

  assert_rel_auto_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> $past(auto_rel && done_valid && done_ok));

  assert_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cf_full && cf_empty) && (cnt <= FULL));

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cf_ovf) && !$past(irq_clr[2])) |-> cf_ovf);

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart_valid |-> (txena && !fail_valid));

endmodule

// File: tb/tb_tx_autorel_ctrl.sv
module tb_tx_autorel_ctrl;
  localparam int PW = 6;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_auto = 0, cpu_txena_set = 0, cf_rd = 0;
  logic [2:0] irq_clr = 0;
  logic done_valid = 0, done_ok = 0, done_fatal = 0, done_last = 0;
  logic [PW-1:0] done_pkt = 0;
  logic auto_rel, txena, rel_valid, cf_empty, cf_full, cf_ovf, irq_tx, irq_txempty;
  logic fail_valid, restart_valid;
  logic [PW-1:0] rel_pkt, cf_dout, fail_pkt, restart_pkt;

  always #10 clk = ~clk;

  tx_autorel_ctrl #(.PKT_W(PW), .CF_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_auto(cfg_auto),
    .cpu_txena_set(cpu_txena_set), .irq_clr(irq_clr), .done_valid(done_valid),
    .done_pkt(done_pkt), .done_ok(done_ok), .done_fatal(done_fatal),
    .done_last(done_last), .cf_rd(cf_rd), .auto_rel(auto_rel), .txena(txena),
    .rel_valid(rel_valid), .rel_pkt(rel_pkt), .cf_dout(cf_dout),
    .cf_empty(cf_empty), .cf_full(cf_full), .cf_ovf(cf_ovf), .irq_tx(irq_tx),
    .irq_txempty(irq_txempty), .fail_valid(fail_valid), .fail_pkt(fail_pkt),
    .restart_valid(restart_valid), .restart_pkt(restart_pkt));

  int checks = 0, errors = 0;
  bit finished = 0;

  int q[$];
  bit m_auto, m_txena, m_rel_v, m_ovf, m_itx, m_iem, m_fail_v, m_rst_v;
  int m_rel_pkt, m_fail_pkt, m_rst_pkt;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_auto = 0; m_txena = 0; m_rel_v = 0; m_ovf = 0; m_itx = 0; m_iem = 0;
      m_fail_v = 0; m_rst_v = 0; m_rel_pkt = 0; m_fail_pkt = 0; m_rst_pkt = 0;
    end else begin
      bit take, fat, wr, was_full, was_fail, setx, sete;
      take = done_valid && m_txena;
      fat = take && done_fatal;
      was_full = (q.size() >= DEPTH);
      was_fail = m_fail_v;
      wr = take && (!m_auto || (!done_ok && !done_fatal));
      setx = fat || (take && !m_auto);
      sete = take && done_last && !done_fatal;
      m_rel_v = take && m_auto && done_ok && !done_fatal;
      if (m_rel_v) m_rel_pkt = done_pkt;
      m_rst_v = cpu_txena_set && was_fail;
      if (m_rst_v) begin m_rst_pkt = m_fail_pkt; m_fail_v = 0; end
      if (fat) begin m_fail_v = 1; m_fail_pkt = done_pkt; end
      if (irq_clr[0]) m_itx = 0;
      if (irq_clr[1]) m_iem = 0;
      if (irq_clr[2]) m_ovf = 0;
      if (setx) m_itx = 1;
      if (sete) m_iem = 1;
      if (wr && was_full) m_ovf = 1;
      if (cf_rd && q.size() > 0) void'(q.pop_front());
      if (wr && !was_full) q.push_back(int'(done_pkt));
      if (fat) m_txena = 0;
      else if (cpu_txena_set) m_txena = 1;
      if (cfg_wr) m_auto = cfg_auto;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R12 auto_rel", auto_rel, m_auto);
    chk("R4/R10 txena", txena, m_txena);
    chk("R2 rel_valid", rel_valid, m_rel_v);
    if (m_rel_v) chk("R2 rel_pkt", rel_pkt, m_rel_pkt);
    chk("R9 cf_empty", cf_empty, q.size() == 0);
    chk("R9 cf_full", cf_full, q.size() == DEPTH);
    if (q.size() > 0) chk("R3/R8 cf_dout", cf_dout, q[0]);
    chk("R9/R11 cf_ovf", cf_ovf, m_ovf);
    chk("R7/R11 irq_tx", irq_tx, m_itx);
    chk("R6/R11 irq_txempty", irq_txempty, m_iem);
    chk("R4 fail_valid", fail_valid, m_fail_v);
    if (m_fail_v) chk("R4 fail_pkt", fail_pkt, m_fail_pkt);
    chk("R10 restart_valid", restart_valid, m_rst_v);
    if (m_rst_v) chk("R10 restart_pkt", restart_pkt, m_rst_pkt);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
    cfg_wr = 0; cpu_txena_set = 0; irq_clr = 0; cf_rd = 0;
    done_valid = 0; done_ok = 0; done_fatal = 0; done_last = 0;
  endtask

  task automatic ev(int pkt, bit ok, bit fatal, bit last);
    done_valid = 1; done_pkt = PW'(pkt); done_ok = ok; done_fatal = fatal; done_last = last;
    step();
  endtask

  task automatic mode(bit a);
    cfg_wr = 1; cfg_auto = a; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 txena", txena, 0); chk("R1 auto", auto_rel, 0);
    chk("R1 empty", cf_empty, 1); chk("R1 full", cf_full, 0);
    chk("R1 irq", {irq_tx, irq_txempty, cf_ovf}, 0);
    chk("R1 fail/rel/restart", {fail_valid, rel_valid, restart_valid}, 0);
    rst_n = 1;
    step();
    // R5 events ignored before enable
    ev(3, 1, 0, 1);
    chk("R5 nothing recorded", {irq_tx, irq_txempty, cf_empty}, 3'b001);
    cpu_txena_set = 1; step();
    // R3 R7 manual mode: all to FIFO in order, irq per packet
    ev(1, 1, 0, 0); ev(2, 0, 0, 0); ev(5, 1, 0, 1);
    for (int i = 0; i < 3; i++) begin cf_rd = 1; step(); end
    irq_clr = 3'b011; step();
    // R2 R6 auto mode: silent releases, irq only at end
    mode(1);
    ev(7, 1, 0, 0); ev(8, 1, 0, 0); ev(9, 1, 0, 1);
    chk("R7 no irq_tx in auto", irq_tx, 0);
    irq_clr = 3'b010; step();
    // R8 non-fatal failure in auto mode
    ev(10, 0, 0, 0);
    cf_rd = 1; step();
    // R4 fatal in auto mode, then R5 events while stopped, R10 restart
    ev(11, 1, 0, 0); ev(12, 1, 1, 0);
    ev(13, 1, 0, 1); ev(14, 0, 0, 0);
    cpu_txena_set = 1; step();
    chk("R10 resumed", txena, 1);
    irq_clr = 3'b001; step();
    // R4 fatal in manual mode also goes into FIFO
    mode(0);
    ev(20, 0, 1, 0);
    cf_rd = 1; step();
    cpu_txena_set = 1; step();
    irq_clr = 3'b011; step();
    // R9 overflow, write-while-full with read dropped
    for (int i = 0; i < DEPTH + 2; i++) ev(30 + i, 1, 0, 0);
    done_valid = 1; done_pkt = 50; done_ok = 1; cf_rd = 1; step();
    for (int i = 0; i < DEPTH + 1; i++) begin cf_rd = 1; step(); end
    // R11 set beats clear
    irq_clr = 3'b111; done_valid = 1; done_pkt = 4; done_ok = 1; done_last = 1; step();
    irq_clr = 3'b111; step();
    // R12 mode write with simultaneous event uses old mode
    cfg_wr = 1; cfg_auto = 1; done_valid = 1; done_pkt = 6; done_ok = 1; step();
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      done_valid = (r < 55); done_pkt = PW'($urandom);
      done_ok = $urandom_range(0, 3) != 0; done_fatal = $urandom_range(0, 11) == 0;
      done_last = $urandom_range(0, 4) == 0;
      cf_rd = $urandom_range(0, 2) == 0;
      cfg_wr = $urandom_range(0, 29) == 0; cfg_auto = $urandom_range(0, 1) == 1;
      cpu_txena_set = (!txena) ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 40) == 0);
      irq_clr = ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'b000;
      step();
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule